// File: doc/BRIEF.md
# Duty-Cycled Burst Sequencer

This block drives the timing of a burst-mode oscillator from the reference clock. Within each period of N reference cycles it first raises a preset strobe, during which the oscillator's control voltages are charged ahead of start-up. The edge counter is held in reset during that same cycle. Next comes one run cycle in which the oscillator is on and its edges are counted. One cycle after that it raises the strobe that tells the loop controller to evaluate the count and update the control word. For the remaining cycles of the period the oscillator stays idle. The oscillator is therefore on for one cycle in N. With a 20 MHz reference and N = 10 this gives a 10% duty cycle.

The period N comes in on an input. It is sampled at the start of every period, so a change made mid-period takes effect from the next period on. Values below 3 are raised to 3, because the preset, run and evaluate slots need at least three cycles. While enable is low the sequencer is idle and drives every output low. The first period begins in the cycle that follows the first clock edge at which enable is sampled high.

Top module: `burst_sequencer`

## Requirements
- R1: While rst is high, and in every cycle after a clock edge that samples enable low, preset, run, count_reset and dco_update are all low.
- R2: preset is high in the first cycle after a clock edge that samples enable high while the sequencer is idle, and in the first cycle of every later period.
- R3: run is high for exactly one cycle per period, namely the cycle immediately after preset.
- R4: count_reset is high in the preset cycle and is low in the run cycle.
- R5: dco_update is a one-cycle pulse, raised in the cycle immediately after the run cycle.
- R6: With a steady period value N of 3 or more, preset recurs every N cycles, and run is low for N-1 cycles between consecutive run cycles.
- R7: A period value below 3 (0, 1 or 2) behaves exactly like 3.
- R8: The period value is sampled only at the clock edge that starts a period. A change during a period does not alter that period's length.
- R9: At most one of preset, run and dco_update is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Starts and keeps the burst schedule running while high |
| period | input | PW (8) | Burst period N in reference cycles; values below 3 are treated as 3 |
| preset | output | 1 | Oscillator preset strobe |
| run | output | 1 | Oscillator run window |
| count_reset | output | 1 | Edge-counter reset |
| dco_update | output | 1 | Control-word update strobe |

## Verification
All outputs are decoded from registers that update at the clock edge. Each result is therefore due in the cycle right after the edge that samples its cause: preset one cycle after enable is sampled high, run one cycle after preset, dco_update one cycle after run, and all outputs low one cycle after enable is sampled low. The bench advances a behavioural model at each rising edge and compares every output against it at the falling edge, where the registered values are stable. Period-length checks count run cycles over fixed windows that span whole periods, both for in-range and for clamped values. A mid-period change of the period is compared cycle by cycle against the model, which keeps the old length until the next period starts.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    localparam int unsigned MIN_PERIOD = 3;

    typedef enum logic [2:0] {
        SL_IDLE,
        SL_PRESET,
        SL_RUN,
        SL_EVAL,
        SL_SLEEP
    } slot_e;

    typedef struct packed {
        logic preset;
        logic run;
        logic cnt_clr;
        logic upd;
    } burst_ctl_t;

    function automatic int unsigned clamp_period(int unsigned n);
        return (n < MIN_PERIOD) ? MIN_PERIOD : n;
    endfunction

endpackage

// File: rtl/bseq_phase_ctr.sv
module bseq_phase_ctr
    import bseq_pkg::*;
#(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enable,
    input  logic [PW-1:0] period_in,
    output logic          active,
    output logic [PW-1:0] phase
);
    localparam logic [PW-1:0] N_MIN = PW'(MIN_PERIOD);

    logic [PW-1:0] n_lat;
    logic [PW-1:0] n_next;
    logic          wrap;

    assign n_next = PW'(clamp_period(32'(period_in)));
    assign wrap   = (phase == n_lat - PW'(1));

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            active <= 1'b0;
            phase  <= '0;
            n_lat  <= N_MIN;
        end else if (!active || wrap) begin
            active <= 1'b1;
            phase  <= '0;
            n_lat  <= n_next;
        end else begin
            phase  <= phase + PW'(1);
        end
    end

    // R7: the latched period never drops below the minimum
    p_clamp_r7: assert property (@(posedge clk) disable iff (rst)
        active |-> (n_lat >= N_MIN));

    // R6: the phase stays inside the current period
    p_phase_bound_r6: assert property (@(posedge clk) disable iff (rst)
        active |-> (phase < n_lat));

    // R8: the latched period changes only when a period starts
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (active && enable && phase != n_lat - PW'(1)) |=> $stable(n_lat));
endmodule

// File: rtl/bseq_slot.sv
module bseq_slot
    import bseq_pkg::*;
#(
    parameter int PW = 8
) (
    input  logic          active,
    input  logic [PW-1:0] phase,
    output slot_e         slot
);
    always_comb begin
        if (!active)                slot = SL_IDLE;
        else if (phase == PW'(0))   slot = SL_PRESET;
        else if (phase == PW'(1))   slot = SL_RUN;
        else if (phase == PW'(2))   slot = SL_EVAL;
        else                        slot = SL_SLEEP;
    end
endmodule

// File: rtl/bseq_decode.sv
module bseq_decode
    import bseq_pkg::*;
(
    input  slot_e      slot,
    output burst_ctl_t ctl
);
    always_comb begin
        ctl = '0;
        case (slot)
            SL_PRESET: begin
                ctl.preset  = 1'b1;
                ctl.cnt_clr = 1'b1;
            end
            SL_RUN:    ctl.run = 1'b1;
            SL_EVAL:   ctl.upd = 1'b1;
            default:   ctl = '0;
        endcase
    end
endmodule

// File: rtl/burst_sequencer.sv
module burst_sequencer
    import bseq_pkg::*;
#(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enable,
    input  logic [PW-1:0] period,
    output logic          preset,
    output logic          run,
    output logic          count_reset,
    output logic          dco_update
);
    logic          active;
    logic [PW-1:0] phase;
    slot_e         slot;
    burst_ctl_t    ctl;

    bseq_phase_ctr #(.PW(PW)) u_ctr (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .period_in (period),
        .active    (active),
        .phase     (phase)
    );

    bseq_slot #(.PW(PW)) u_slot (
        .active (active),
        .phase  (phase),
        .slot   (slot)
    );

    bseq_decode u_dec (
        .slot (slot),
        .ctl  (ctl)
    );

    assign preset      = ctl.preset;
    assign run         = ctl.run;
    assign count_reset = ctl.cnt_clr;
    assign dco_update  = ctl.upd;

    // R1: enable sampled low leaves every output low
    p_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !(preset || run || count_reset || dco_update));

    // R3: a preset slot is followed by the run slot
    p_run_after_preset_r3: assert property (@(posedge clk) disable iff (rst)
        (preset && enable) |=> run);

    // R3: the run window lasts one cycle
    p_run_single_r3: assert property (@(posedge clk) disable iff (rst)
        run |=> !run);

    // R4: the counter is released while running
    p_clr_released_r4: assert property (@(posedge clk) disable iff (rst)
        run |-> !count_reset);

    // R5: the update strobe follows the run cycle
    p_update_after_run_r5: assert property (@(posedge clk) disable iff (rst)
        (run && enable) |=> dco_update);

    // R5: the update strobe is one cycle wide
    p_update_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        dco_update |=> !dco_update);

    // R9: preset, run and update never overlap
    p_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({preset, run, dco_update}));
endmodule

// File: tb/test_burst_sequencer.sv
module test_burst_sequencer;
    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          enable = 1'b0;
    logic [PW-1:0] period = 8'd10;
    logic          preset, run, count_reset, dco_update;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int run_total = 0;
    string focus = "R1";

    // behavioural model state
    bit m_on = 1'b0;
    int m_pos = 0;
    int m_len = 3;

    always #4 clk = ~clk;

    burst_sequencer #(.PW(PW)) i_burst_sequencer (
        .clk         (clk),
        .rst         (rst),
        .enable      (enable),
        .period      (period),
        .preset      (preset),
        .run         (run),
        .count_reset (count_reset),
        .dco_update  (dco_update)
    );

    function automatic int eff_len(int p);
        return (p < 3) ? 3 : p;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (rst || !enable) begin
            m_on = 1'b0;
            m_pos = 0;
        end else if (!m_on) begin
            m_on = 1'b1;
            m_pos = 0;
            m_len = eff_len(int'(period));
        end else begin
            m_pos++;
            if (m_pos >= m_len) begin
                m_pos = 0;
                m_len = eff_len(int'(period));
            end
        end
    end

    task automatic check_bit(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s (%s) %s at cycle %0d: actual %b expected %b",
                     req, focus, what, cycles, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (run === 1'b1) run_total++;
        if (!m_on) begin
            check_bit("R1", "preset", preset, 1'b0);
            check_bit("R1", "run", run, 1'b0);
            check_bit("R1", "count_reset", count_reset, 1'b0);
            check_bit("R1", "dco_update", dco_update, 1'b0);
        end else begin
            check_bit("R2", "preset", preset, m_pos == 0);
            check_bit("R4", "count_reset", count_reset, m_pos == 0);
            check_bit("R3", "run", run, m_pos == 1);
            check_bit("R5", "dco_update", dco_update, m_pos == 2);
        end
        checks++;
        if ((int'(preset) + int'(run) + int'(dco_update)) > 1) begin
            errors++;
            $display("FAIL R9 overlap at cycle %0d: actual %b%b%b expected at most one high",
                     cycles, preset, run, dco_update);
        end
    end

    task automatic wait_cycles(int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic check_runs(string req, int window, int exp);
        int start;
        start = run_total;
        wait_cycles(window);
        checks++;
        if (run_total - start != exp) begin
            errors++;
            $display("FAIL %s run count over %0d cycles: actual %0d expected %0d",
                     req, window, run_total - start, exp);
        end
    endtask

    initial begin
        wait_cycles(3);
        rst = 1'b0;
        wait_cycles(2);

        // R2 / R3 / R5: first burst after enable
        focus = "R2";
        period = 8'd10;
        enable = 1'b1;
        wait_cycles(5);

        // R6: ten runs in any 100-cycle window with N = 10
        focus = "R6";
        check_runs("R6", 100, 10);

        // R1: drop enable mid-stream
        focus = "R1";
        enable = 1'b0;
        wait_cycles(6);

        // R7: period values below 3 behave like 3
        focus = "R7";
        period = 8'd0;
        enable = 1'b1;
        wait_cycles(3);
        check_runs("R7", 30, 10);
        period = 8'd1;
        check_runs("R7", 30, 10);
        period = 8'd2;
        check_runs("R7", 30, 10);

        // R6: minimum legal and other in-range lengths
        focus = "R6";
        period = 8'd3;
        check_runs("R6", 30, 10);
        period = 8'd7;
        wait_cycles(3);
        check_runs("R6", 70, 10);

        // R8: change the period mid-period; model keeps the old length
        focus = "R8";
        enable = 1'b0;
        wait_cycles(2);
        period = 8'd12;
        enable = 1'b1;
        wait_cycles(5);
        period = 8'd4;
        wait_cycles(40);
        check_runs("R8", 40, 10);

        // R1: reset while running
        focus = "R1";
        rst = 1'b1;
        wait_cycles(3);
        rst = 1'b0;
        enable = 1'b0;
        wait_cycles(3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule